// File: doc/BRIEF.md
# Resistance Ratio Slope Sequencer

This block runs a four-phase charge and discharge measurement on an RC network. It first charges a capacitor and then lets it discharge through a known reference resistor. It then charges the capacitor again and lets it discharge through the sensor resistor. A comparator reports when the capacitor voltage has dropped below a fixed threshold. The block counts clock periods from the start of each discharge until that trip. The two counts are proportional to the two time constants, so a host divides them to get the sensor resistance as a multiple of the reference.

The block drives three switch enables: charge, reference discharge and sensor discharge. It never enables two of them at once, and every phase change passes through one clock with all three off. The charge time is set per run by an input. It is sampled when a run is accepted. A discharge that does not trip before the counter saturates ends the run early, with a flag set. Both counts then stay on the outputs until the next run starts.

Top module: `rratio_seq`

## Requirements
- R1: After reset, all three switch enables, `busy`, `done` and `overflow` are low, and both counts are zero.
- R2: At most one of `sw_charge`, `sw_ref`, `sw_sens` is high in any cycle.
- R3: A `start` sampled high while idle begins a run. From the next cycle the phases are charge, reference discharge, charge and sensor discharge, with exactly one all-off clock between consecutive phases. Without overflow the run takes 2L+Dr+Ds+5 cycles from the accepting edge to `done` (L, Dr, Ds as in R4 and R5).
- R4: Each charge phase lasts L = `charge_len` clocks, where a value of 0 counts as 1. The value is taken at the accepting edge, and later changes do not affect the run in progress.
- R5: A discharge count is the number of clock edges in that discharge phase before the edge at which `cmp_below` is sampled high. A trip seen at the first edge of the phase gives 0.
- R6: The comparator may still be low at the edge where the discharge count equals 2^CNT_W-1. In that case the count reports that saturated value and `overflow` is set. The run then ends at once with `done`, and the sensor count stays 0 if the reference discharge overflowed.
- R7: A `start` raised while `busy` is high has no effect on the run, its timing or its results, and it does not queue another run.
- R8: `done` is high for exactly one cycle, in the first idle cycle after the last phase. `busy` is low in that same cycle.
- R9: An accepted `start` clears both counts and `overflow` to zero in the next cycle. While idle without `start`, the counts and `overflow` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a measurement run (used only when idle) |
| charge_len | input | CHG_W | Charge phase length in clocks (0 acts as 1) |
| cmp_below | input | 1 | Comparator: capacitor voltage is below threshold |
| sw_charge | output | 1 | Charge switch enable |
| sw_ref | output | 1 | Reference-resistor discharge switch enable |
| sw_sens | output | 1 | Sensor-resistor discharge switch enable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| overflow | output | 1 | A discharge saturated the counter |
| ref_count | output | CNT_W | Reference discharge count |
| sens_count | output | CNT_W | Sensor discharge count |

## Verification
The assertions assume that `cmp_below` is synchronous to `clk` and reflects the network only while a discharge switch is on. They also assume that `charge_len` is stable at the accepting edge. The bench drives the comparator from a model that counts clocks while either discharge enable is high and trips once a programmed delay is reached. It holds the comparator low in every other phase. All inputs change at falling edges, so each input is settled before the rising edge that samples it.

// File: rtl/rratio_pkg.sv
package rratio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_CHG_A   = 3'd1,
    PH_GAP_A   = 3'd2,
    PH_DIS_REF = 3'd3,
    PH_GAP_B   = 3'd4,
    PH_CHG_B   = 3'd5,
    PH_GAP_C   = 3'd6,
    PH_DIS_SEN = 3'd7
  } phase_e;

  typedef struct packed {
    logic chg;
    logic dref;
    logic dsen;
  } sw_t;

  function automatic sw_t phase_switches(phase_e p);
    sw_t s;
    s.chg  = (p == PH_CHG_A) || (p == PH_CHG_B);
    s.dref = (p == PH_DIS_REF);
    s.dsen = (p == PH_DIS_SEN);
    return s;
  endfunction

endpackage

// File: rtl/rratio_settle_timer.sv
module rratio_settle_timer #(
  parameter int CHG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CHG_W-1:0] len_in,
  input  logic             run,
  output logic             expire
);
  localparam logic [CHG_W-1:0] ONE = {{(CHG_W-1){1'b0}}, 1'b1};

  logic [CHG_W-1:0] len_q, len_d;
  logic [CHG_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;

  always_comb begin
    len_d  = (len_in == '0) ? ONE : len_in;
    tmr_en = run || (tmr_q != '0);
    tmr_d  = run ? (expire ? '0 : tmr_q + ONE) : '0;
  end

  assign expire = run && (tmr_q == len_q - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= ONE;
      tmr_q <= '0;
    end else begin
      if (load)   len_q <= len_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  // R4: the timer never runs past the programmed length
  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (tmr_q < len_q));

endmodule

// File: rtl/rratio_slope_counter.sv
module rratio_slope_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  assign at_max = (cnt == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  // R6: the counter saturates, it is never stepped from its maximum
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> !at_max);

endmodule

// File: rtl/rratio_phase_fsm.sv
module rratio_phase_fsm
  import rratio_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   settle_done,
  input  logic   cmp_below,
  input  logic   at_max,
  output phase_e phase,
  output logic   accept,
  output logic   chg_run,
  output logic   cnt_inc,
  output logic   cnt_clr,
  output logic   cap_ref,
  output logic   cap_sen,
  output logic   ovf_evt,
  output logic   end_evt
);
  phase_e phase_d;

  always_comb begin
    phase_d = phase;
    accept  = 1'b0;
    chg_run = 1'b0;
    cnt_inc = 1'b0;
    cnt_clr = 1'b1;
    cap_ref = 1'b0;
    cap_sen = 1'b0;
    ovf_evt = 1'b0;
    end_evt = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        accept  = 1'b1;
        phase_d = PH_CHG_A;
      end
      PH_CHG_A: begin
        chg_run = 1'b1;
        if (settle_done) phase_d = PH_GAP_A;
      end
      PH_GAP_A: phase_d = PH_DIS_REF;
      PH_DIS_REF: begin
        cnt_clr = 1'b0;
        if (cmp_below) begin
          cap_ref = 1'b1;
          phase_d = PH_GAP_B;
        end else if (at_max) begin
          cap_ref = 1'b1;
          ovf_evt = 1'b1;
          end_evt = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      PH_GAP_B: phase_d = PH_CHG_B;
      PH_CHG_B: begin
        chg_run = 1'b1;
        if (settle_done) phase_d = PH_GAP_C;
      end
      PH_GAP_C: phase_d = PH_DIS_SEN;
      PH_DIS_SEN: begin
        cnt_clr = 1'b0;
        if (cmp_below) begin
          cap_sen = 1'b1;
          end_evt = 1'b1;
          phase_d = PH_IDLE;
        end else if (at_max) begin
          cap_sen = 1'b1;
          ovf_evt = 1'b1;
          end_evt = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  // R3: leaving idle always enters the first charge phase
  assert_enter_charge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_IDLE && phase != PH_IDLE) |-> phase == PH_CHG_A);

endmodule

// File: rtl/rratio_seq.sv
module rratio_seq
  import rratio_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CHG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CHG_W-1:0] charge_len,
  input  logic             cmp_below,
  output logic             sw_charge,
  output logic             sw_ref,
  output logic             sw_sens,
  output logic             busy,
  output logic             done,
  output logic             overflow,
  output logic [CNT_W-1:0] ref_count,
  output logic [CNT_W-1:0] sens_count
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  phase_e           phase;
  sw_t              sw;
  logic             accept, chg_run, cnt_inc, cnt_clr;
  logic             cap_ref, cap_sen, ovf_evt, end_evt;
  logic             settle_done, at_max;
  logic [CNT_W-1:0] cnt;

  rratio_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .settle_done (settle_done),
    .cmp_below   (cmp_below),
    .at_max      (at_max),
    .phase       (phase),
    .accept      (accept),
    .chg_run     (chg_run),
    .cnt_inc     (cnt_inc),
    .cnt_clr     (cnt_clr),
    .cap_ref     (cap_ref),
    .cap_sen     (cap_sen),
    .ovf_evt     (ovf_evt),
    .end_evt     (end_evt)
  );

  rratio_settle_timer #(.CHG_W(CHG_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .len_in (charge_len),
    .run    (chg_run),
    .expire (settle_done)
  );

  rratio_slope_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .cnt    (cnt),
    .at_max (at_max)
  );

  assign sw        = phase_switches(phase);
  assign sw_charge = sw.chg;
  assign sw_ref    = sw.dref;
  assign sw_sens   = sw.dsen;
  assign busy      = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_count  <= '0;
      sens_count <= '0;
      overflow   <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= end_evt;
      if (accept)       ref_count  <= '0;
      else if (cap_ref) ref_count  <= cnt;
      if (accept)       sens_count <= '0;
      else if (cap_sen) sens_count <= cnt;
      if (accept)       overflow   <= 1'b0;
      else if (ovf_evt) overflow   <= 1'b1;
    end
  end

  assert_one_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_charge, sw_ref, sw_sens}) <= 1);

  assert_gap_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past({sw_charge, sw_ref, sw_sens}) != 3'b000) &&
     ({sw_charge, sw_ref, sw_sens} != $past({sw_charge, sw_ref, sw_sens})))
    |-> ({sw_charge, sw_ref, sw_sens} == 3'b000));

  assert_ovf_saturated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (ref_count == SAT || sens_count == SAT));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(ref_count) && $stable(sens_count) && $stable(overflow)));

endmodule

// File: tb/tb_rratio_seq.sv
module tb_rratio_seq;
  localparam int CNT_W = 8;
  localparam int CHG_W = 6;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int NVEC  = 8;
  // charge_len, ref delay, sens delay, exp ref, exp sens, exp overflow
  localparam int VEC [NVEC][6] = '{
    '{4,  10,  20,  10,  20,  0},
    '{1,  0,   0,   0,   0,   0},
    '{0,  3,   7,   3,   7,   0},
    '{63, 100, 50,  100, 50,  0},
    '{8,  255, 1,   255, 1,   0},
    '{5,  256, 9,   255, 0,   1},
    '{5,  12,  400, 12,  255, 1},
    '{2,  40,  40,  40,  40,  0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CHG_W-1:0] charge_len = '0;
  logic             cmp_below;
  logic             sw_charge, sw_ref, sw_sens, busy, done, overflow;
  logic [CNT_W-1:0] ref_count, sens_count;

  int total = 0;
  int bad = 0;
  int dref = 0;
  int dsen = 0;
  int k = 0;
  int cyc = 0;
  int sw_viol = 0;
  logic [2:0] sw_prev = 3'b000;

  always #10 clk = ~clk;

  rratio_seq #(.CNT_W(CNT_W), .CHG_W(CHG_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .charge_len (charge_len),
    .cmp_below  (cmp_below),
    .sw_charge  (sw_charge),
    .sw_ref     (sw_ref),
    .sw_sens    (sw_sens),
    .busy       (busy),
    .done       (done),
    .overflow   (overflow),
    .ref_count  (ref_count),
    .sens_count (sens_count)
  );

  // comparator model: trips after a programmed number of discharge clocks
  assign cmp_below = (sw_ref && (k >= dref)) || (sw_sens && (k >= dsen));

  always @(posedge clk) begin
    if (sw_ref || sw_sens) k <= k + 1;
    else                   k <= 0;
  end

  // switch monitor for R2 and R3
  always @(negedge clk) begin
    logic [2:0] cur;
    cur = {sw_charge, sw_ref, sw_sens};
    if ($countones(cur) > 1) sw_viol++;
    if (sw_prev != 3'b000 && cur != 3'b000 && cur != sw_prev) sw_viol++;
    sw_prev = cur;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_one(input int len, input int dr, input int ds,
                         input int er, input int es, input int eo, input int inj);
    int leff, rc, sc, lat, n;
    bit rovf, sovf;
    logic [CNT_W-1:0] r_hold, s_hold;
    leff = (len == 0) ? 1 : len;
    rovf = dr > MAXC;
    sovf = !rovf && ds > MAXC;
    rc   = rovf ? MAXC + 1 : dr + 1;
    sc   = sovf ? MAXC + 1 : ds + 1;
    lat  = leff + 1 + rc + (rovf ? 0 : 1 + leff + 1 + sc);
    @(negedge clk);
    charge_len = len[CHG_W-1:0];
    dref = dr;
    dsen = ds;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: accepted start clears the results
    chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
    chk(ref_count == 0 && sens_count == 0 && overflow == 1'b0, "R9 clear on start",
        int'(ref_count) + int'(sens_count) + int'(overflow), 0);
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
      if (inj > 0 && n == inj) begin
        start = 1'b1;
        charge_len = 6'd50;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(n == lat, "R3 R4 R7 run latency", n, lat);
    chk(int'(ref_count) == er, "R5 R6 R7 ref count", int'(ref_count), er);
    chk(int'(sens_count) == es, "R5 R6 R7 sens count", int'(sens_count), es);
    chk(int'(overflow) == eo, "R6 overflow flag", int'(overflow), eo);
    chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
    r_hold = ref_count;
    s_hold = sens_count;
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    repeat (4) @(negedge clk);
    chk(ref_count == r_hold && sens_count == s_hold && busy == 1'b0,
        "R7 R9 results held, no queued run", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({sw_charge, sw_ref, sw_sens} == 3'b000, "R1 switches off", int'({sw_charge, sw_ref, sw_sens}), 0);
    chk(!busy && !done && !overflow, "R1 flags low", int'({busy, done, overflow}), 0);
    chk(ref_count == 0 && sens_count == 0, "R1 counts zero", int'(ref_count) + int'(sens_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++)
      run_one(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], 0);

    // R7 and R4: start and a new charge length during a run are ignored
    run_one(4, 10, 20, 10, 20, 0, 3);
    run_one(3, 15, 5, 15, 5, 0, 30);

    // R2 R3: switch monitor results
    chk(sw_viol == 0, "R2 R3 switch exclusivity and gap clocks", sw_viol, 0);

    // R1: asynchronous reset in the middle of a run
    @(negedge clk);
    charge_len = 6'd10;
    dref = 30;
    dsen = 30;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (14) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({sw_charge, sw_ref, sw_sens, busy, done, overflow} == 6'b0, "R1 reset mid-run",
        int'({sw_charge, sw_ref, sw_sens, busy}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule